// File: doc/BRIEF.md
# Ethernet Controller Command and Status Register Unit

This unit is the host's only window into an Ethernet controller's control state. The host does not address the registers directly. It first writes a register number to a select port. Every later access to the data port then goes to the register that is selected. Four registers sit behind the data port:

- a 16-bit control/status word that mixes command bits, an interrupt enable and event flags;
- two words that together form the address of the controller's initialization block;
- a small bus-control word.

The rest of the controller receives one-cycle start, stop, init and transmit-demand pulses. It returns event strobes for these conditions:

- initialization done, frame received and frame transmitted;
- babble, collision error, missed frame and memory error.

The unit collects these events as flags and raises one interrupt line. Event flags clear when a one is written to them, and the command bits share the same word. A single host write can therefore acknowledge events and issue a command together.

The data port always presents the selected register's current contents. The host reads it with no read strobe.

Top module: `eth_csr_bank`

## Requirements
- R1: After a synchronous reset the unit is stopped. The control word reads 0x0004 (only STOP set) and register 0 is selected. The address and bus-control registers are zero and all pulse and interrupt outputs are low.
- R2: A select-port write loads the register number: 0 is the control word, 1 the low address word, 2 the high address word and 3 the bus-control word. Every data-port write goes to the register selected before that clock edge. `dat_dout` shows the register selected after it.
- R3: Registers 1 to 3 accept data writes only while the STOP bit (bit 2) is set, and ignore them otherwise. `init_ptr` is register 2 above register 1, the low 16 address bits coming from register 1.
- R4: Writing the control word with bit 2 (STOP) set always stops the unit, whatever else the word holds. The write gives one `stop_pulse` and no other pulse. It sets STOP and clears STRT, INIT, TDMD, RXON, TXON, INEA and every event flag.
- R5: Writing bit 1 (STRT) without STOP clears STOP and sets STRT (bit 1), RXON (bit 5) and TXON (bit 4). It also gives one `start_pulse`.
- R6: Writing bit 0 (INIT) without STOP clears STOP, sets INIT and gives one `init_pulse`. A later init-done event sets IDON (bit 8) and clears INIT.
- R7: Writing bit 3 (TDMD) while running (STOP clear) gives one `tdmd_pulse` and sets TDMD, which stays set until a transmit-done event. While stopped, the TDMD bit has no effect.
- R8: While running, events set these flags: babble BABL (bit 14), collision error CERR (13), missed frame MISS (12), memory error MERR (11), receive done RINT (10), transmit done TINT (9) and init done IDON (8). While stopped, events are ignored and no flag is set.
- R9: Writing one to a flag bit clears that flag and writing zero leaves it unchanged. An event that arrives on the same edge as a clear leaves the flag set.
- R10: Bit 15 (ERR) reads as the OR of bits 14 to 11, and bit 7 (INTR) reads as the OR of bits 14 to 8. Writes to bits 15, 7, 5 and 4 have no effect.
- R11: Bit 6 (INEA) takes the written value on every control-word write. `irq` is high exactly when INTR and INEA are both set.
- R12: All outputs are registered. `dat_dout`, `irq`, `init_ptr` and `bus_cfg` show the effect of a write or event in the cycle right after the edge that samples it. The pulses are high for exactly that one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sel_we | input | 1 | Select-port write strobe |
| sel_din | input | 2 | Register number to select |
| dat_we | input | 1 | Data-port write strobe |
| dat_din | input | 16 | Data-port write value |
| dat_dout | output | 16 | Selected register contents |
| ev_init_done | input | 1 | Initialization finished |
| ev_rx_done | input | 1 | Frame received |
| ev_tx_done | input | 1 | Frame transmitted |
| ev_babble | input | 1 | Transmit babble |
| ev_coll_err | input | 1 | Collision error |
| ev_missed | input | 1 | Receive frame missed |
| ev_mem_err | input | 1 | Memory access error |
| start_pulse | output | 1 | Start command |
| stop_pulse | output | 1 | Stop command |
| init_pulse | output | 1 | Initialize command |
| tdmd_pulse | output | 1 | Transmit poll demand |
| irq | output | 1 | Interrupt request |
| init_ptr | output | ADDR_W | Initialization block address |
| bus_cfg | output | BCTL_W | Bus-control setting |

## Verification
The bench goes after these conflicts and corner cases:

- A stop word that also carries start, init and demand bits. A design with the priority wrong would leave the unit running or emit extra pulses.
- An event on the same edge as its write-one clear. A design with the wrong order would lose the event.
- A select write and a data write in the same cycle. A design that routes the data to the new selection would corrupt the wrong register.
- Address writes while running, and demand writes or events while stopped. These must leave no trace: a design that misses the gating would move `init_ptr`, pulse `tdmd_pulse` or raise flags with the unit halted.

A long randomized run then mixes all of these against the reference model on every clock.

// File: rtl/eth_csr_pkg.sv
package eth_csr_pkg;

  localparam int CSR_W = 16;
  localparam int SEL_W = 2;
  localparam int EV_N  = 7;

  // control word bit positions (host-visible layout)
  localparam int B_ERR  = 15;
  localparam int B_FLAG_HI = 14;
  localparam int B_FLAG_LO = 8;
  localparam int B_INTR = 7;
  localparam int B_INEA = 6;
  localparam int B_RXON = 5;
  localparam int B_TXON = 4;
  localparam int B_TDMD = 3;
  localparam int B_STOP = 2;
  localparam int B_STRT = 1;
  localparam int B_INIT = 0;

  typedef enum logic [SEL_W-1:0] {
    RSEL_CTRL   = 2'd0,
    RSEL_PTR_LO = 2'd1,
    RSEL_PTR_HI = 2'd2,
    RSEL_BUS    = 2'd3
  } rsel_e;

  // flag order matches bits 14..8 of the control word
  typedef struct packed {
    logic babl;
    logic cerr;
    logic miss;
    logic merr;
    logic rint;
    logic tint;
    logic idon;
  } evflags_t;

  typedef struct packed {
    logic     stop;
    logic     strt;
    logic     init;
    logic     tdmd;
    logic     rxon;
    logic     txon;
    logic     inea;
    evflags_t fl;
  } ctl_state_t;

  localparam ctl_state_t CTL_RESET = '{stop: 1'b1, default: '0};

  function automatic logic [CSR_W-1:0] pack_ctl(input ctl_state_t s);
    logic [CSR_W-1:0] w;
    w = '0;
    w[B_FLAG_HI:B_FLAG_LO] = s.fl;
    w[B_ERR]  = s.fl.babl | s.fl.cerr | s.fl.miss | s.fl.merr;
    w[B_INTR] = |s.fl;
    w[B_INEA] = s.inea;
    w[B_RXON] = s.rxon;
    w[B_TXON] = s.txon;
    w[B_TDMD] = s.tdmd;
    w[B_STOP] = s.stop;
    w[B_STRT] = s.strt;
    w[B_INIT] = s.init;
    return w;
  endfunction

endpackage

// File: rtl/eth_csr_sel.sv
module eth_csr_sel
  import eth_csr_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             sel_we,
  input  logic [SEL_W-1:0] sel_din,
  output rsel_e            sel_q,
  output rsel_e            sel_next
);

  always_comb begin
    sel_next = sel_q;
    if (sel_we) sel_next = rsel_e'(sel_din);
  end

  always_ff @(posedge clk) begin
    if (rst) sel_q <= RSEL_CTRL;
    else     sel_q <= sel_next;
  end

endmodule

// File: rtl/eth_csr_cfg_word.sv
module eth_csr_cfg_word #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         we,
  input  logic [W-1:0] din,
  output logic [W-1:0] q,
  output logic [W-1:0] q_next
);

  always_comb begin
    q_next = q;
    if (we) q_next = din;
  end

  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= q_next;
  end

endmodule

// File: rtl/eth_csr_ctl.sv
module eth_csr_ctl
  import eth_csr_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [CSR_W-1:0] wdata,
  input  evflags_t         ev,
  output ctl_state_t       st_q,
  output ctl_state_t       st_next,
  output logic             start_pulse,
  output logic             stop_pulse,
  output logic             init_pulse,
  output logic             tdmd_pulse,
  output logic             irq
);

  logic start_d, stop_d, init_d, tdmd_d, irq_d;
  logic unused_ro_bits;

  // summary and run-status bits are read-only
  assign unused_ro_bits = ^{wdata[B_ERR], wdata[B_INTR], wdata[B_RXON], wdata[B_TXON]};

  always_comb begin
    st_next = st_q;
    start_d = 1'b0;
    stop_d  = 1'b0;
    init_d  = 1'b0;
    tdmd_d  = 1'b0;
    if (wr_en && wdata[B_STOP]) begin
      // stop dominates every other bit of the same word
      st_next      = '0;
      st_next.stop = 1'b1;
      stop_d       = 1'b1;
    end else begin
      if (wr_en) begin
        st_next.fl   = st_next.fl & ~evflags_t'(wdata[B_FLAG_HI:B_FLAG_LO]);
        st_next.inea = wdata[B_INEA];
      end
      if (!st_q.stop) begin
        st_next.fl = st_next.fl | ev;
        if (ev.idon) st_next.init = 1'b0;
        if (ev.tint) st_next.tdmd = 1'b0;
      end
      if (wr_en && wdata[B_STRT]) begin
        st_next.stop = 1'b0;
        st_next.strt = 1'b1;
        st_next.rxon = 1'b1;
        st_next.txon = 1'b1;
        start_d      = 1'b1;
      end
      if (wr_en && wdata[B_INIT]) begin
        st_next.stop = 1'b0;
        st_next.init = 1'b1;
        init_d       = 1'b1;
      end
      if (wr_en && wdata[B_TDMD] && !st_q.stop) begin
        st_next.tdmd = 1'b1;
        tdmd_d       = 1'b1;
      end
    end
    irq_d = st_next.inea & (|st_next.fl);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q        <= CTL_RESET;
      start_pulse <= 1'b0;
      stop_pulse  <= 1'b0;
      init_pulse  <= 1'b0;
      tdmd_pulse  <= 1'b0;
      irq         <= 1'b0;
    end else begin
      st_q        <= st_next;
      start_pulse <= start_d;
      stop_pulse  <= stop_d;
      init_pulse  <= init_d;
      tdmd_pulse  <= tdmd_d;
      irq         <= irq_d;
    end
  end

endmodule

// File: rtl/eth_csr_rdmux.sv
module eth_csr_rdmux
  import eth_csr_pkg::*;
#(
  parameter int HI_W   = 8,
  parameter int BCTL_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  rsel_e             sel,
  input  logic [CSR_W-1:0]  ctl_word,
  input  logic [CSR_W-1:0]  lo_word,
  input  logic [HI_W-1:0]   hi_word,
  input  logic [BCTL_W-1:0] bus_word,
  output logic [CSR_W-1:0]  dout
);

  logic [CSR_W-1:0] hi_ext, bus_ext, dout_d;

  always_comb begin
    hi_ext  = '0;
    bus_ext = '0;
    hi_ext[HI_W-1:0]    = hi_word;
    bus_ext[BCTL_W-1:0] = bus_word;
    unique case (sel)
      RSEL_CTRL:   dout_d = ctl_word;
      RSEL_PTR_LO: dout_d = lo_word;
      RSEL_PTR_HI: dout_d = hi_ext;
      default:     dout_d = bus_ext;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) dout <= pack_ctl(CTL_RESET);
    else     dout <= dout_d;
  end

endmodule

// File: rtl/eth_csr_bank.sv
module eth_csr_bank
  import eth_csr_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int BCTL_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sel_we,
  input  logic [1:0]        sel_din,
  input  logic              dat_we,
  input  logic [15:0]       dat_din,
  output logic [15:0]       dat_dout,
  input  logic              ev_init_done,
  input  logic              ev_rx_done,
  input  logic              ev_tx_done,
  input  logic              ev_babble,
  input  logic              ev_coll_err,
  input  logic              ev_missed,
  input  logic              ev_mem_err,
  output logic              start_pulse,
  output logic              stop_pulse,
  output logic              init_pulse,
  output logic              tdmd_pulse,
  output logic              irq,
  output logic [ADDR_W-1:0] init_ptr,
  output logic [BCTL_W-1:0] bus_cfg
);

  localparam int LO_W = CSR_W;
  localparam int HI_W = ADDR_W - LO_W;

  rsel_e      sel_q, sel_next;
  ctl_state_t ctl_q, ctl_next;
  evflags_t   ev;
  logic       wr_ctl, wr_lo, wr_hi, wr_bus;
  logic [LO_W-1:0]   lo_q, lo_next;
  logic [HI_W-1:0]   hi_q, hi_next;
  logic [BCTL_W-1:0] bus_q, bus_next;

  assign ev = '{babl: ev_babble, cerr: ev_coll_err, miss: ev_missed, merr: ev_mem_err,
                rint: ev_rx_done, tint: ev_tx_done, idon: ev_init_done};

  // data writes target the selection held before this edge
  assign wr_ctl = dat_we && (sel_q == RSEL_CTRL);
  assign wr_lo  = dat_we && (sel_q == RSEL_PTR_LO) && ctl_q.stop;
  assign wr_hi  = dat_we && (sel_q == RSEL_PTR_HI) && ctl_q.stop;
  assign wr_bus = dat_we && (sel_q == RSEL_BUS)    && ctl_q.stop;

  eth_csr_sel u_sel (
    .clk(clk), .rst(rst), .sel_we(sel_we), .sel_din(sel_din),
    .sel_q(sel_q), .sel_next(sel_next)
  );

  eth_csr_ctl u_ctl (
    .clk(clk), .rst(rst), .wr_en(wr_ctl), .wdata(dat_din), .ev(ev),
    .st_q(ctl_q), .st_next(ctl_next),
    .start_pulse(start_pulse), .stop_pulse(stop_pulse),
    .init_pulse(init_pulse), .tdmd_pulse(tdmd_pulse), .irq(irq)
  );

  eth_csr_cfg_word #(.W(LO_W)) u_ptr_lo (
    .clk(clk), .rst(rst), .we(wr_lo), .din(dat_din[LO_W-1:0]),
    .q(lo_q), .q_next(lo_next)
  );

  eth_csr_cfg_word #(.W(HI_W)) u_ptr_hi (
    .clk(clk), .rst(rst), .we(wr_hi), .din(dat_din[HI_W-1:0]),
    .q(hi_q), .q_next(hi_next)
  );

  eth_csr_cfg_word #(.W(BCTL_W)) u_bus (
    .clk(clk), .rst(rst), .we(wr_bus), .din(dat_din[BCTL_W-1:0]),
    .q(bus_q), .q_next(bus_next)
  );

  eth_csr_rdmux #(.HI_W(HI_W), .BCTL_W(BCTL_W)) u_rd (
    .clk(clk), .rst(rst), .sel(sel_next), .ctl_word(pack_ctl(ctl_next)),
    .lo_word(lo_next), .hi_word(hi_next), .bus_word(bus_next), .dout(dat_dout)
  );

  assign init_ptr = {hi_q, lo_q};
  assign bus_cfg  = bus_q;

endmodule

// File: rtl/eth_csr_bank_chk.sv
module eth_csr_bank_chk
  import eth_csr_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int BCTL_W = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              sel_we,
  input logic [1:0]        sel_din,
  input logic              dat_we,
  input logic [15:0]       dat_din,
  input logic              ev_init_done,
  input logic              ev_rx_done,
  input logic              start_pulse,
  input logic              stop_pulse,
  input logic              init_pulse,
  input logic              tdmd_pulse,
  input logic              irq,
  input logic [ADDR_W-1:0] init_ptr,
  input logic [BCTL_W-1:0] bus_cfg,
  input rsel_e             sel_q,
  input ctl_state_t        ctl_q
);

  logic ctl_wr;
  assign ctl_wr = dat_we && (sel_q == RSEL_CTRL);

  a_r2_sel_load: assert property (@(posedge clk) disable iff (rst)
    sel_we |=> (sel_q == rsel_e'($past(sel_din))));

  a_r3_cfg_locked: assert property (@(posedge clk) disable iff (rst)
    (dat_we && sel_q != RSEL_CTRL && !ctl_q.stop) |=> ($stable(init_ptr) && $stable(bus_cfg)));

  a_r4_stop_wins: assert property (@(posedge clk) disable iff (rst)
    (ctl_wr && dat_din[B_STOP]) |=> (stop_pulse && !start_pulse && !init_pulse && !tdmd_pulse && ctl_q.stop));

  a_r5_start_runs: assert property (@(posedge clk) disable iff (rst)
    (ctl_wr && dat_din[B_STRT] && !dat_din[B_STOP]) |=> (!ctl_q.stop && ctl_q.rxon && ctl_q.txon));

  a_r6_idon_set: assert property (@(posedge clk) disable iff (rst)
    (ev_init_done && !ctl_q.stop && !(ctl_wr && dat_din[B_STOP])) |=> ctl_q.fl.idon);

  a_r7_tdmd_gated: assert property (@(posedge clk) disable iff (rst)
    ctl_q.stop |=> !tdmd_pulse);

  a_r8_quiet_stopped: assert property (@(posedge clk) disable iff (rst)
    ctl_q.stop |-> (!irq && ctl_q.fl == '0));

  a_r9_w1c: assert property (@(posedge clk) disable iff (rst)
    (ctl_wr && dat_din[10] && !ev_rx_done) |=> !ctl_q.fl.rint);

  a_r11_irq_inea: assert property (@(posedge clk) disable iff (rst)
    irq |-> (ctl_q.inea && (|ctl_q.fl)));

  a_r12_pulse_excl: assert property (@(posedge clk) disable iff (rst)
    $onehot0({start_pulse, stop_pulse}));

endmodule

bind eth_csr_bank eth_csr_bank_chk #(.ADDR_W(ADDR_W), .BCTL_W(BCTL_W)) u_chk (
  .clk(clk), .rst(rst), .sel_we(sel_we), .sel_din(sel_din), .dat_we(dat_we),
  .dat_din(dat_din), .ev_init_done(ev_init_done), .ev_rx_done(ev_rx_done),
  .start_pulse(start_pulse), .stop_pulse(stop_pulse), .init_pulse(init_pulse),
  .tdmd_pulse(tdmd_pulse), .irq(irq), .init_ptr(init_ptr), .bus_cfg(bus_cfg),
  .sel_q(sel_q), .ctl_q(ctl_q)
);

// File: tb/eth_csr_bank_bench.sv
`timescale 1ns/1ps
module eth_csr_bank_bench;

  localparam int ADDR_W = 24;
  localparam int BCTL_W = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sel_we = 1'b0;
  logic [1:0] sel_din = '0;
  logic dat_we = 1'b0;
  logic [15:0] dat_din = '0;
  logic [15:0] dat_dout;
  logic ev_init_done = 0, ev_rx_done = 0, ev_tx_done = 0, ev_babble = 0;
  logic ev_coll_err = 0, ev_missed = 0, ev_mem_err = 0;
  logic start_pulse, stop_pulse, init_pulse, tdmd_pulse, irq;
  logic [ADDR_W-1:0] init_ptr;
  logic [BCTL_W-1:0] bus_cfg;

  always #2 clk = ~clk;

  eth_csr_bank #(.ADDR_W(ADDR_W), .BCTL_W(BCTL_W)) u_eth_csr_bank (
    .clk(clk), .rst(rst), .sel_we(sel_we), .sel_din(sel_din), .dat_we(dat_we),
    .dat_din(dat_din), .dat_dout(dat_dout), .ev_init_done(ev_init_done),
    .ev_rx_done(ev_rx_done), .ev_tx_done(ev_tx_done), .ev_babble(ev_babble),
    .ev_coll_err(ev_coll_err), .ev_missed(ev_missed), .ev_mem_err(ev_mem_err),
    .start_pulse(start_pulse), .stop_pulse(stop_pulse), .init_pulse(init_pulse),
    .tdmd_pulse(tdmd_pulse), .irq(irq), .init_ptr(init_ptr), .bus_cfg(bus_cfg)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // behavioural reference state
  int m_sel;
  bit m_stop, m_strt, m_init, m_tdmd, m_rxon, m_txon, m_inea;
  bit [6:0] m_fl;               // {babl,cerr,miss,merr,rint,tint,idon}
  int m_lo, m_hi, m_bc;
  bit m_p_start, m_p_stop, m_p_init, m_p_tdmd;

  task automatic check(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic bit [15:0] m_word();
    bit [15:0] w;
    w = 16'(m_init) | (16'(m_strt) << 1) | (16'(m_stop) << 2) | (16'(m_tdmd) << 3)
      | (16'(m_txon) << 4) | (16'(m_rxon) << 5) | (16'(m_inea) << 6)
      | (16'(m_fl != 0) << 7) | (16'(m_fl) << 8) | (16'(m_fl[6:3] != 0) << 15);
    return w;
  endfunction

  function automatic int m_dout();
    case (m_sel)
      0: return int'(m_word());
      1: return m_lo;
      2: return m_hi;
      default: return m_bc;
    endcase
  endfunction

  task automatic m_reset();
    m_sel = 0; m_stop = 1; m_strt = 0; m_init = 0; m_tdmd = 0;
    m_rxon = 0; m_txon = 0; m_inea = 0; m_fl = 0;
    m_lo = 0; m_hi = 0; m_bc = 0;
    m_p_start = 0; m_p_stop = 0; m_p_init = 0; m_p_tdmd = 0;
  endtask

  task automatic m_step(input bit swe, input int sv, input bit dwe, input int dv, input bit [6:0] ev);
    bit was_stop;
    was_stop = m_stop;
    m_p_start = 0; m_p_stop = 0; m_p_init = 0; m_p_tdmd = 0;
    if (dwe) begin
      if (m_sel == 0) begin
        if (dv[2]) begin
          m_stop = 1; m_strt = 0; m_init = 0; m_tdmd = 0; m_rxon = 0; m_txon = 0;
          m_inea = 0; m_fl = 0; m_p_stop = 1;
        end else begin
          m_fl = m_fl & ~7'(dv >> 8);
          m_inea = dv[6];
          if (!was_stop) begin
            m_fl = m_fl | ev;
            if (ev[0]) m_init = 0;
            if (ev[1]) m_tdmd = 0;
          end
          if (dv[1]) begin m_stop = 0; m_strt = 1; m_rxon = 1; m_txon = 1; m_p_start = 1; end
          if (dv[0]) begin m_stop = 0; m_init = 1; m_p_init = 1; end
          if (dv[3] && !was_stop) begin m_tdmd = 1; m_p_tdmd = 1; end
        end
      end else begin
        if (!was_stop) begin
          m_fl = m_fl | ev;
          if (ev[0]) m_init = 0;
          if (ev[1]) m_tdmd = 0;
        end
        if (was_stop) begin
          if (m_sel == 1) m_lo = dv & 16'hFFFF;
          else if (m_sel == 2) m_hi = dv & 8'hFF;
          else m_bc = dv & 3'h7;
        end
      end
    end else if (!was_stop) begin
      m_fl = m_fl | ev;
      if (ev[0]) m_init = 0;
      if (ev[1]) m_tdmd = 0;
    end
    if (swe) m_sel = sv;
  endtask

  task automatic compare_all();
    check(m_sel == 0 ? "R10" : "R3", dat_dout, m_dout());
    check("R11", irq, m_inea && (m_fl != 0));
    check("R5", start_pulse, m_p_start);
    check("R4", stop_pulse, m_p_stop);
    check("R6", init_pulse, m_p_init);
    check("R7", tdmd_pulse, m_p_tdmd);
    check("R3", init_ptr, (m_hi << 16) | m_lo);
    check("R3", bus_cfg, m_bc);
  endtask

  // called at a negative edge; returns at the next negative edge
  task automatic cyc(input bit swe, input int sv, input bit dwe, input int dv, input bit [6:0] ev);
    sel_we = swe; sel_din = 2'(sv); dat_we = dwe; dat_din = 16'(dv);
    {ev_babble, ev_coll_err, ev_missed, ev_mem_err, ev_rx_done, ev_tx_done, ev_init_done} = ev;
    @(posedge clk);
    m_step(swe, sv, dwe, dv, ev);
    @(negedge clk);
    sel_we = 0; dat_we = 0;
    {ev_babble, ev_coll_err, ev_missed, ev_mem_err, ev_rx_done, ev_tx_done, ev_init_done} = '0;
    compare_all();
  endtask

  task automatic wr(input int dv); cyc(0, 0, 1, dv, 0); endtask
  task automatic sel(input int sv); cyc(1, sv, 0, 0, 0); endtask
  task automatic evt(input bit [6:0] ev); cyc(0, 0, 0, 0, ev); endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    m_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    // R1: reset state
    check("R1", dat_dout, 16'h0004);
    check("R1", init_ptr, 0);
    check("R1", {start_pulse, stop_pulse, init_pulse, tdmd_pulse, irq}, 0);
    compare_all();

    // R3: configure while stopped; R2: read back through selection
    sel(1); wr(16'hBEEF);
    sel(2); wr(16'h0012);
    sel(3); wr(16'h0005);
    check("R3", init_ptr, 24'h12BEEF);
    check("R3", bus_cfg, 3'h5);
    sel(1);
    check("R2", dat_dout, 16'hBEEF);
    // R2: select and data write together -> data goes to old selection (1)
    cyc(1, 2, 1, 16'h1234, 0);
    check("R2", dat_dout, 16'h0012);
    check("R2", init_ptr, 24'h121234);
    sel(0);

    // R5: start
    wr(16'h0002);
    check("R5", dat_dout, 16'h0032);
    // R3: write to address while running is ignored
    sel(1); wr(16'h1111);
    check("R3", dat_dout, 16'h1234);
    sel(0);

    // R8, R10, R11
    evt(7'b1000000);
    check("R10", dat_dout, 16'hC0B2);
    check("R11", irq, 0);
    wr(16'h0040);
    check("R11", irq, 1);
    check("R11", dat_dout, 16'hC0F2);
    // R9: clear by one
    wr(16'h4040);
    check("R9", dat_dout, 16'h0072);
    check("R9", irq, 0);
    evt(7'b0000100);
    check("R8", dat_dout, 16'h04F2);
    wr(16'h0040);
    check("R9", dat_dout, 16'h04F2);
    cyc(0, 0, 1, 16'h0440, 7'b0000100);
    check("R9", dat_dout, 16'h04F2);
    wr(16'h0440);
    check("R9", dat_dout, 16'h0072);
    // R10: read-only bits ignored
    wr(16'h80C0);
    check("R10", dat_dout, 16'h0072);

    // R7: transmit demand
    wr(16'h0048);
    check("R7", tdmd_pulse, 1);
    check("R7", dat_dout, 16'h007A);
    evt(7'b0000010);
    check("R7", dat_dout, 16'h02F2);

    // R4: stop dominates
    wr(16'h004F);
    check("R4", {start_pulse, stop_pulse, init_pulse, tdmd_pulse}, 4'b0100);
    check("R4", dat_dout, 16'h0004);
    check("R4", irq, 0);
    // R7: demand while stopped
    wr(16'h0008);
    check("R7", tdmd_pulse, 0);
    check("R7", dat_dout, 16'h0004);
    // R8: events while stopped
    evt(7'b1111111);
    check("R8", dat_dout, 16'h0004);

    // R6: init sequence
    wr(16'h0001);
    check("R6", init_pulse, 1);
    check("R6", dat_dout, 16'h0001);
    evt(7'b0000001);
    check("R6", dat_dout, 16'h0180);

    // randomized mix; R12 timing is covered by the per-cycle compare
    for (int i = 0; i < 4000; i++) begin
      bit swe, dwe;
      int dv;
      bit [6:0] ev;
      swe = ($urandom_range(0, 5) == 0);
      dwe = ($urandom_range(0, 2) == 0);
      dv  = int'($urandom_range(0, 65535));
      if ($urandom_range(0, 7) != 0) dv = dv & ~32'h4;
      ev = 0;
      for (int k = 0; k < 7; k++) ev[k] = ($urandom_range(0, 4) == 0);
      cyc(swe, int'($urandom_range(0, 3)), dwe, dv, ev);
    end
    check("R12", dat_dout, m_dout());

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule